// File: doc/BRIEF.md
# Receive Packet Length and Error Checker

This block sits on the application side of a wide packet receive interface. Each beat can carry up to eight 64-bit words. Along with the words come these qualifiers:

- a start flag;
- a 4-bit end field;
- a destination channel;
- a 4-bit count of valid words;
- an error flag.

The block does not store the payload. It only watches the qualifiers. It follows every packet from its start beat to its end beat, keeps the channel given on the start beat, and adds up the packet's byte length. When a packet closes, it produces one descriptor holding the channel, the byte length and a good/drop verdict.

For each of 16 channels it keeps a saturating good-packet counter and a saturating dropped-packet counter. These are read through a select input. Framing violations raise a one-cycle protocol-error pulse. A downstream consumer uses the descriptors to commit or discard the payload it has buffered itself.

Top module: `rx_pkt_len_chk`

## Requirements
- R1: A beat with `beat_valid_i` and `sop_i` high opens a packet, and `chan_i` is captured on that beat only. The channel value on later beats of the packet has no effect on the descriptor.
- R2: A valid beat of an open packet that is not its end beat adds `nwords_i`*8 bytes to the packet length, so a full beat (`nwords_i`=8) adds 64 bytes.
- R3: On the end beat (`eop_i[3]`=1), the beat adds (`nwords_i`-1)*8 + B bytes. B is `eop_i[2:0]`, and the code 3'b000 means B=8.
- R4: One cycle after an end beat of an open packet, `desc_valid_o` is high for exactly one cycle together with the captured channel, the total length and `desc_good_o`.
- R5: If `err_i` is high on any beat of a packet, from its start beat through its end beat, that packet's descriptor has `desc_good_o`=0.
- R6: Beats with `beat_valid_i` low change no state and produce no descriptor and no protocol error, including when they fall inside an open packet.
- R7: A beat with both start and end set forms a single-beat packet. Its length comes from that beat alone by the R3 formula.
- R8: A valid beat without start while no packet is open raises `proto_err_o` for one cycle in the next cycle, gives no descriptor, and is otherwise ignored.
- R9: A start beat while a packet is open raises `proto_err_o` in the next cycle, together with a drop descriptor for the open packet (its channel and the length accumulated so far). The start beat then opens the new packet. If that start beat also carries an end, the new packet is discarded without a descriptor.
- R10: Every descriptor whose channel is below 16 increments that channel's good counter (when `desc_good_o`=1) or its drop counter (otherwise). The update is visible on `good_cnt_o`/`drop_cnt_o` for `cnt_sel_i` one cycle after the descriptor. Descriptors for channels of 16 and above change no counter.
- R11: The counters saturate at all-ones (255 with the default 8-bit width).
- R12: After reset no packet is open, `desc_valid_o` and `proto_err_o` are low, and all counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| beat_valid_i | input | 1 | Beat qualifiers are valid |
| sop_i | input | 1 | Start-of-packet beat |
| eop_i | input | 4 | [3] end-of-packet beat, [2:0] byte count of last valid word (0 = 8) |
| nwords_i | input | 4 | Number of valid 64-bit words in the beat (1..8) |
| chan_i | input | 8 | Destination channel, sampled on start beats |
| err_i | input | 1 | Beat belongs to a corrupted packet |
| desc_valid_o | output | 1 | Descriptor strobe |
| desc_chan_o | output | 8 | Descriptor channel |
| desc_len_o | output | 16 | Descriptor byte length |
| desc_good_o | output | 1 | 1 = good packet, 0 = drop |
| proto_err_o | output | 1 | One-cycle framing-violation pulse |
| cnt_sel_i | input | 4 | Channel select for counter read |
| good_cnt_o | output | 8 | Good-packet count of selected channel |
| drop_cnt_o | output | 8 | Dropped-packet count of selected channel |

## Verification
The hardest state to reach from the ports is an unexpected start beat that cuts into a packet which has already built up a partial length. The abort descriptor must then carry the old channel and the old partial sum, while the new packet keeps counting from its own start beat. The bench first opens a two-beat packet on one channel. It then sends a start on another channel, and after that closes the new packet to confirm that its length excludes the aborted bytes. Counter saturation is reached by running a burst of back-to-back single-beat packets on one channel, more than the counter can hold.

// File: rtl/rx_pkt_pkg.sv
package rx_pkt_pkg;
  localparam int CHAN_W     = 8;
  localparam int LEN_W      = 16;
  localparam int WORD_BYTES = 8;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [LEN_W-1:0]  len;
    logic              good;
  } desc_t;
endpackage

// File: rtl/rx_beat_len.sv
module rx_beat_len
  import rx_pkt_pkg::*;
#(
  parameter int MAX_WORDS = 8
) (
  input  logic             eop_i,
  input  logic [2:0]       last_bytes_i,
  input  logic [3:0]       nwords_i,
  output logic [LEN_W-1:0] len_o
);
  logic [3:0]       nw_clamp;
  logic [LEN_W-1:0] tail;

  always_comb begin
    nw_clamp = (nwords_i > 4'(MAX_WORDS)) ? 4'(MAX_WORDS) : nwords_i;
    tail     = (last_bytes_i == 3'd0) ? LEN_W'(WORD_BYTES) : LEN_W'(last_bytes_i);
    if (!eop_i)
      len_o = LEN_W'(nw_clamp) * LEN_W'(WORD_BYTES);
    else if (nw_clamp == 4'd0)
      len_o = '0;
    else
      len_o = LEN_W'(nw_clamp - 4'd1) * LEN_W'(WORD_BYTES) + tail;
  end
endmodule

// File: rtl/rx_pkt_track.sv
module rx_pkt_track
  import rx_pkt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              err_i,
  input  logic [LEN_W-1:0]  beat_len_i,
  output desc_t             desc_o,
  output logic              desc_valid_o,
  output logic              proto_err_o,
  output logic              open_o
);
  logic              open_q, open_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              err_q, err_d;
  desc_t             desc_q, desc_d;
  logic              dv_q, dv_d;
  logic              perr_q, perr_d;

  always_comb begin
    open_d = open_q;
    chan_d = chan_q;
    len_d  = len_q;
    err_d  = err_q;
    desc_d = '0;
    dv_d   = 1'b0;
    perr_d = 1'b0;
    if (beat_valid_i) begin
      if (sop_i) begin
        if (open_q) begin
          // abort open packet; new start is still honoured
          perr_d = 1'b1;
          dv_d   = 1'b1;
          desc_d = '{chan: chan_q, len: len_q, good: 1'b0};
          open_d = !eop_i;
        end else if (eop_i) begin
          dv_d   = 1'b1;
          desc_d = '{chan: chan_i, len: beat_len_i, good: !err_i};
          open_d = 1'b0;
        end else begin
          open_d = 1'b1;
        end
        chan_d = chan_i;
        len_d  = beat_len_i;
        err_d  = err_i;
      end else if (open_q) begin
        if (eop_i) begin
          dv_d   = 1'b1;
          desc_d = '{chan: chan_q, len: len_q + beat_len_i, good: !(err_q | err_i)};
          open_d = 1'b0;
        end else begin
          len_d = len_q + beat_len_i;
          err_d = err_q | err_i;
        end
      end else begin
        perr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      chan_q <= '0;
      len_q  <= '0;
      err_q  <= 1'b0;
      desc_q <= '0;
      dv_q   <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      open_q <= open_d;
      chan_q <= chan_d;
      len_q  <= len_d;
      err_q  <= err_d;
      desc_q <= desc_d;
      dv_q   <= dv_d;
      perr_q <= perr_d;
    end
  end

  assign desc_o       = desc_q;
  assign desc_valid_o = dv_q;
  assign proto_err_o  = perr_q;
  assign open_o       = open_q;
endmodule

// File: rtl/rx_chan_counters.sv
module rx_chan_counters
  import rx_pkt_pkg::*;
#(
  parameter int NUM_CHAN = 16,
  parameter int CNT_W    = 8,
  localparam int SEL_W   = $clog2(NUM_CHAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              good_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [CNT_W-1:0]  good_cnt_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  logic [CNT_W-1:0] good_q [NUM_CHAN];
  logic [CNT_W-1:0] drop_q [NUM_CHAN];

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic hit;
    assign hit = upd_i && (chan_i == CHAN_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        good_q[c] <= '0;
        drop_q[c] <= '0;
      end else if (hit) begin
        if (good_i && !(&good_q[c])) good_q[c] <= good_q[c] + 1'b1;
        if (!good_i && !(&drop_q[c])) drop_q[c] <= drop_q[c] + 1'b1;
      end
    end
  end

  assign good_cnt_o = good_q[sel_i];
  assign drop_cnt_o = drop_q[sel_i];
endmodule

// File: rtl/rx_pkt_len_chk.sv
module rx_pkt_len_chk
  import rx_pkt_pkg::*;
#(
  parameter int NUM_CHAN  = 16,
  parameter int CNT_W     = 8,
  parameter int MAX_WORDS = 8,
  localparam int SEL_W    = $clog2(NUM_CHAN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              beat_valid_i,
  input  logic              sop_i,
  input  logic [3:0]        eop_i,
  input  logic [3:0]        nwords_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              err_i,
  output logic              desc_valid_o,
  output logic [CHAN_W-1:0] desc_chan_o,
  output logic [LEN_W-1:0]  desc_len_o,
  output logic              desc_good_o,
  output logic              proto_err_o,
  input  logic [SEL_W-1:0]  cnt_sel_i,
  output logic [CNT_W-1:0]  good_cnt_o,
  output logic [CNT_W-1:0]  drop_cnt_o
);
  logic [LEN_W-1:0] beat_len;
  desc_t            desc;
  logic             pkt_open;

  rx_beat_len #(.MAX_WORDS(MAX_WORDS)) u_len (
    .eop_i        (eop_i[3]),
    .last_bytes_i (eop_i[2:0]),
    .nwords_i     (nwords_i),
    .len_o        (beat_len)
  );

  rx_pkt_track u_trk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .beat_valid_i (beat_valid_i),
    .sop_i        (sop_i),
    .eop_i        (eop_i[3]),
    .chan_i       (chan_i),
    .err_i        (err_i),
    .beat_len_i   (beat_len),
    .desc_o       (desc),
    .desc_valid_o (desc_valid_o),
    .proto_err_o  (proto_err_o),
    .open_o       (pkt_open)
  );

  rx_chan_counters #(.NUM_CHAN(NUM_CHAN), .CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (desc_valid_o),
    .chan_i     (desc.chan),
    .good_i     (desc.good),
    .sel_i      (cnt_sel_i),
    .good_cnt_o (good_cnt_o),
    .drop_cnt_o (drop_cnt_o)
  );

  assign desc_chan_o = desc.chan;
  assign desc_len_o  = desc.len;
  assign desc_good_o = desc.good;
endmodule

// File: rtl/rx_pkt_len_chk_sva.sv
module rx_pkt_len_chk_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       beat_valid_i,
  input logic       sop_i,
  input logic [3:0] eop_i,
  input logic [7:0] chan_i,
  input logic       err_i,
  input logic       pkt_open,
  input logic       desc_valid_o,
  input logic [7:0] desc_chan_o,
  input logic       desc_good_o,
  input logic       proto_err_o
);
  assert_end_gives_desc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && !sop_i && eop_i[3] && pkt_open) |=> (desc_valid_o && !proto_err_o));

  assert_err_end_drops_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && !sop_i && eop_i[3] && pkt_open && err_i) |=> (desc_valid_o && !desc_good_o));

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_valid_i |=> (!desc_valid_o && !proto_err_o && $stable(pkt_open)));

  assert_single_beat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && sop_i && eop_i[3] && !pkt_open && !err_i)
      |=> (desc_valid_o && desc_good_o && desc_chan_o == $past(chan_i)));

  assert_orphan_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && !sop_i && !pkt_open) |=> (proto_err_o && !desc_valid_o));

  assert_abort_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_i && sop_i && pkt_open) |=> (proto_err_o && desc_valid_o && !desc_good_o));
endmodule

bind rx_pkt_len_chk rx_pkt_len_chk_sva u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .beat_valid_i (beat_valid_i),
  .sop_i        (sop_i),
  .eop_i        (eop_i),
  .chan_i       (chan_i),
  .err_i        (err_i),
  .pkt_open     (pkt_open),
  .desc_valid_o (desc_valid_o),
  .desc_chan_o  (desc_chan_o),
  .desc_good_o  (desc_good_o),
  .proto_err_o  (proto_err_o)
);

// File: tb/sim_rx_pkt_len_chk.sv
`timescale 1ns/1ps
module sim_rx_pkt_len_chk;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       beat_valid_i = 1'b0;
  logic       sop_i = 1'b0;
  logic [3:0] eop_i = '0;
  logic [3:0] nwords_i = '0;
  logic [7:0] chan_i = '0;
  logic       err_i = 1'b0;
  logic       desc_valid_o, desc_good_o, proto_err_o;
  logic [7:0] desc_chan_o;
  logic [15:0] desc_len_o;
  logic [3:0] cnt_sel_i = '0;
  logic [7:0] good_cnt_o, drop_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  rx_pkt_len_chk u0 (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus; return just after the capturing edge
  task automatic beat(bit v, bit s, bit e, int eb, int nw, int ch, bit er);
    @(negedge clk_i);
    beat_valid_i = v; sop_i = s; eop_i = {e, 3'(eb)}; nwords_i = 4'(nw);
    chan_i = 8'(ch); err_i = er;
    @(posedge clk_i); #1;
    beat_valid_i = 1'b0; sop_i = 1'b0; eop_i = '0; err_i = 1'b0;
  endtask

  task automatic idle();
    beat(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic exp_desc(string req, int ch, int len, int good);
    chk(req, "desc_valid", desc_valid_o, 1);
    chk(req, "desc_chan", desc_chan_o, ch);
    chk(req, "desc_len", desc_len_o, len);
    chk(req, "desc_good", desc_good_o, good);
    chk(req, "proto_err", proto_err_o, 0);
  endtask

  task automatic exp_quiet(string req);
    chk(req, "desc_valid", desc_valid_o, 0);
    chk(req, "proto_err", proto_err_o, 0);
  endtask

  task automatic exp_cnt(string req, int ch, int g, int d);
    @(negedge clk_i);
    cnt_sel_i = 4'(ch);
    #1;
    chk(req, $sformatf("good_cnt[%0d]", ch), good_cnt_o, g);
    chk(req, $sformatf("drop_cnt[%0d]", ch), drop_cnt_o, d);
  endtask

  task automatic t_reset();
    exp_quiet("R12");
    for (int c = 0; c < 16; c++) exp_cnt("R12", c, 0, 0);
  endtask

  // 179 bytes: 8 words, 8 words, 7 words with 3 bytes in the last; channel changes on later beats (R1)
  task automatic t_long_good();
    beat(1, 1, 0, 0, 8, 2, 0); exp_quiet("R2");
    beat(1, 0, 0, 0, 8, 9, 0); exp_quiet("R2");
    beat(1, 0, 1, 3, 7, 11, 0);
    exp_desc("R1_R3", 2, 179, 1);
    idle(); exp_quiet("R4");
    exp_cnt("R10", 2, 1, 0);
  endtask

  // idle cycles between and inside a 139-byte packet
  task automatic t_idle_gaps();
    idle(); idle(); exp_quiet("R6");
    beat(1, 1, 0, 0, 8, 3, 0);
    idle(); exp_quiet("R6");
    beat(1, 0, 0, 0, 8, 3, 0);
    idle(); idle(); exp_quiet("R6");
    beat(1, 0, 1, 3, 2, 3, 0);
    exp_desc("R6", 3, 139, 1);
  endtask

  // error on middle beat only: sticky until end
  task automatic t_err_sticky();
    beat(1, 1, 0, 0, 8, 2, 0);
    beat(1, 0, 0, 0, 8, 2, 1);
    beat(1, 0, 1, 3, 7, 2, 0);
    exp_desc("R5", 2, 179, 0);
    idle();
    exp_cnt("R10", 2, 1, 1);
    // error on start beat of a single-beat packet
    beat(1, 1, 1, 1, 1, 6, 1);
    exp_desc("R5", 6, 1, 0);
  endtask

  task automatic t_single_beat();
    beat(1, 1, 1, 0, 3, 7, 0);
    exp_desc("R7_R3", 7, 24, 1);
    beat(1, 1, 1, 5, 8, 7, 0);
    exp_desc("R7", 7, 61, 1);
    beat(1, 1, 1, 0, 8, 7, 0);
    exp_desc("R7", 7, 64, 1);
  endtask

  task automatic t_orphan();
    beat(1, 0, 1, 2, 4, 1, 0);
    chk("R8", "proto_err", proto_err_o, 1);
    chk("R8", "desc_valid", desc_valid_o, 0);
    idle();
    chk("R8", "proto_err pulse", proto_err_o, 0);
    beat(1, 0, 0, 0, 8, 1, 0);
    chk("R8", "proto_err mid", proto_err_o, 1);
    chk("R8", "desc_valid mid", desc_valid_o, 0);
    exp_cnt("R8", 1, 0, 0);
  endtask

  task automatic t_abort();
    beat(1, 1, 0, 0, 8, 4, 0);
    beat(1, 0, 0, 0, 8, 4, 0);
    beat(1, 1, 0, 0, 8, 5, 0);
    chk("R9", "proto_err", proto_err_o, 1);
    chk("R9", "desc_valid", desc_valid_o, 1);
    chk("R9", "desc_chan", desc_chan_o, 4);
    chk("R9", "desc_len", desc_len_o, 128);
    chk("R9", "desc_good", desc_good_o, 0);
    beat(1, 0, 1, 5, 1, 5, 0);
    exp_desc("R9", 5, 69, 1);
    // start+end while open: abort descriptor only, new packet discarded
    beat(1, 1, 0, 0, 8, 8, 0);
    beat(1, 1, 1, 0, 2, 9, 0);
    chk("R9", "proto_err se", proto_err_o, 1);
    chk("R9", "desc_chan se", desc_chan_o, 8);
    chk("R9", "desc_good se", desc_good_o, 0);
    idle(); exp_quiet("R9");
    exp_cnt("R9", 9, 0, 0);
    exp_cnt("R10", 4, 0, 1);
  endtask

  task automatic t_high_chan();
    beat(1, 1, 1, 0, 1, 20, 0);
    exp_desc("R10", 20, 8, 1);
    idle();
    exp_cnt("R10", 4, 0, 1);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 260; i++) beat(1, 1, 1, 0, 1, 12, 0);
    idle();
    exp_cnt("R11", 12, 255, 0);
  endtask

  initial begin
    #25 rst_ni = 1'b1;
    t_reset();
    t_long_good();
    t_idle_gaps();
    t_err_sticky();
    t_single_beat();
    t_orphan();
    t_abort();
    t_high_chan();
    t_saturate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule